// File: doc/BRIEF.md
# Planar Display Memory Read Port with Plane Latch

This block serves host reads from a display memory organised as parallel bit planes. A host read presents every plane's byte from one address at once. On that read the block captures all plane bytes into a wide latch and returns a single byte to the host. The latch is kept for the write side of the graphics pipeline, which uses it as its second operand.

The returned byte depends on a one-bit mode input. In plane mode it is the raw byte of one plane, chosen by a plane index. In match mode each result bit reports whether one pixel matches a reference color. A pixel is the column of bits at the same position across the planes. A per-plane enable mask decides which planes take part in the comparison. Address decoding and the write datapath live outside this block.

Top module: `planar_read_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_data` and `latch_q` are 0 after that edge.
- R2: After an edge with `rd_stb`=1 and `rd_mode`=0, `rd_data` equals the byte of plane `map_sel` from `plane_data`. Plane p occupies bits 8p+7..8p.
- R3: After an edge with `rd_stb`=1 and `rd_mode`=1, `rd_data` bit i is 1 exactly when pixel i matches `cmp_color` on every enabled plane. Pixel i is bit i of each plane byte, and plane p's reference is `cmp_color[p]`.
- R4: In match mode, a plane whose `cmp_care` bit is 0 has no influence on the result, whatever its data.
- R5: In match mode with `cmp_care` = 0, `rd_data` is 0xFF.
- R6: On every edge with `rd_stb`=1, in either mode, `latch_q` takes the full `plane_data` word. Plane p occupies bits 8p+7..8p.
- R7: On edges with `rd_stb`=0, `latch_q` and `rd_data` keep their values, whatever the other inputs do.
- R8: Results appear on the edge that samples `rd_stb`, so they are visible one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| rd_mode | input | 1 | 0 selects plane byte, 1 selects color match |
| map_sel | input | 2 | Plane index for plane mode |
| cmp_color | input | 4 | Reference color, one bit per plane |
| cmp_care | input | 4 | Per-plane comparison enable |
| plane_data | input | 32 | Bytes of all planes at the read address |
| rd_data | output | 8 | Registered host read byte |
| latch_q | output | 32 | Plane latch for the write datapath |

## Verification
The bench builds the block with its defaults: four planes of eight pixels each. This makes every plane index and every one of the sixteen enable masks reachable, including the empty mask. Directed vectors pin down single-plane mismatches, masked-plane independence and holding between strobes. A long random stream then mixes modes, idle cycles and strobes against a behavioural model on every clock.

// File: rtl/planar_read_pkg.sv
package planar_read_pkg;
  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_MATCH = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pread_plane_mux.sv
module pread_plane_mux #(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic [BUS_W-1:0]  plane_bus,
  input  logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    byte_o = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (sel == SEL_W'(p)) byte_o = plane_bus[p*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/pread_color_match.sv
module pread_color_match #(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic [BUS_W-1:0]  plane_bus,
  input  logic [PLANES-1:0] color,
  input  logic [PLANES-1:0] care,
  output logic [BYTE_W-1:0] match
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_pix
    logic [PLANES-1:0] miss;
    for (genvar p = 0; p < PLANES; p++) begin : g_pl
      assign miss[p] = care[p] & (plane_bus[p*BYTE_W + i] ^ color[p]);
    end
    assign match[i] = ~|miss;
  end
endmodule

// File: rtl/pread_latch.sv
module pread_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  a_r6_latch_load: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/planar_read_unit.sv
module planar_read_unit
  import planar_read_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1,
  localparam int BUS_W = PLANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              rd_mode,
  input  logic [SEL_W-1:0]  map_sel,
  input  logic [PLANES-1:0] cmp_color,
  input  logic [PLANES-1:0] cmp_care,
  input  logic [BUS_W-1:0]  plane_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BUS_W-1:0]  latch_q
);
  logic [BYTE_W-1:0] plane_byte;
  logic [BYTE_W-1:0] match_vec;
  logic [BYTE_W-1:0] rd_next;

  pread_plane_mux #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_mux (
    .plane_bus(plane_data), .sel(map_sel), .byte_o(plane_byte));

  pread_color_match #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_match (
    .plane_bus(plane_data), .color(cmp_color), .care(cmp_care),
    .match(match_vec));

  pread_latch #(.WIDTH(BUS_W)) u_latch (
    .clk(clk), .rst(rst), .load(rd_stb), .d(plane_data), .q(latch_q));

  always_comb begin
    rd_next = (rd_mode_e'(rd_mode) == RD_MATCH) ? match_vec : plane_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= rd_next;
  end

  function automatic logic [BYTE_W-1:0] plane_of(input logic [BUS_W-1:0] w,
                                                  input logic [SEL_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int p = 0; p < PLANES; p++)
      if (int'(s) == p) r = w[p*BYTE_W +: BYTE_W];
    return r;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && latch_q == '0));
  a_r2_plane_from_latch: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_mode) |=> rd_data == plane_of(latch_q, $past(map_sel)));
  a_r5_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_mode && cmp_care == '0) |=> rd_data == '1);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/test_planar_read_unit.sv
module test_planar_read_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_stb;
  logic        rd_mode;
  logic [1:0]  map_sel;
  logic [3:0]  cmp_color;
  logic [3:0]  cmp_care;
  logic [31:0] plane_data;
  logic [7:0]  rd_data;
  logic [31:0] latch_q;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0]  exp_rd  = '0;
  logic [31:0] exp_lat = '0;

  always #(PERIOD/2) clk = ~clk;

  planar_read_unit i_planar_read_unit (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_mode(rd_mode),
    .map_sel(map_sel), .cmp_color(cmp_color), .cmp_care(cmp_care),
    .plane_data(plane_data), .rd_data(rd_data), .latch_q(latch_q));

  function automatic logic [7:0] model_match(logic [31:0] d, logic [3:0] col,
                                             logic [3:0] cr);
    logic [7:0] res;
    res = 8'hFF;
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 4; p++)
        if (cr[p] && (d[8*p+i] != col[p])) res[i] = 1'b0;
    return res;
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (rd_data !== exp_rd || latch_q !== exp_lat) begin
      errors++;
      $display("FAIL %s: rd_data=%h latch_q=%h expected rd_data=%h latch_q=%h",
               tag, rd_data, latch_q, exp_rd, exp_lat);
    end
  endtask

  task automatic step(input logic stb, input logic md, input logic [1:0] sel,
                      input logic [3:0] col, input logic [3:0] cr,
                      input logic [31:0] d, input string tag);
    rd_stb = stb; rd_mode = md; map_sel = sel;
    cmp_color = col; cmp_care = cr; plane_data = d;
    if (stb) begin
      exp_lat = d;
      exp_rd  = md ? model_match(d, col, cr) : d[8*sel +: 8];
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rd_stb = 1'b1; rd_mode = 1'b0; map_sel = 2'd1;
    cmp_color = '0; cmp_care = '0; plane_data = 32'hDEADBEEF;
    @(posedge clk); @(posedge clk); #1;
    exp_rd = '0; exp_lat = '0;
    compare("R1 reset");
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #1;
    do_reset();
    // R2 / R8: each plane index, one cycle latency
    for (int s = 0; s < 4; s++)
      step(1, 0, 2'(s), 4'h0, 4'h0, 32'h44332211, "R2 R8 plane byte");
    // R7: idle cycles with changing inputs
    step(0, 1, 2'd3, 4'hF, 4'hF, 32'h00000000, "R7 hold");
    step(0, 0, 2'd0, 4'h5, 4'h3, 32'hFFFFFFFF, "R7 hold");
    // R3: all planes enabled, color 0101 against pixel pattern
    step(1, 1, 2'd0, 4'b0101, 4'hF, 32'h00FF00FF, "R3 full match");
    step(1, 1, 2'd0, 4'b0101, 4'hF, 32'h00FF00FE, "R3 pixel0 miss");
    step(1, 1, 2'd0, 4'b1010, 4'hF, 32'hF00FF00F, "R3 mixed");
    // R4: disabled plane 3 garbage does not change result
    step(1, 1, 2'd0, 4'b0011, 4'b0111, 32'h00FFFF00, "R4 masked plane");
    step(1, 1, 2'd0, 4'b1011, 4'b0111, 32'hA5FFFF00, "R4 masked plane");
    // R5: empty mask
    step(1, 1, 2'd2, 4'hA, 4'h0, 32'h12345678, "R5 empty mask");
    // R6: latch loads in both modes
    step(1, 0, 2'd3, 4'h0, 4'h0, 32'hCAFEF00D, "R6 latch mode0");
    step(1, 1, 2'd3, 4'h0, 4'h1, 32'h0BADBEEF, "R6 latch mode1");
    // R1: reset in the middle
    do_reset();
    // random stream
    for (int n = 0; n < 3000; n++) begin
      logic m;
      m = 1'($urandom);
      step(1'($urandom_range(0, 3) != 0), m, 2'($urandom), 4'($urandom),
           4'($urandom), $urandom, m ? "R3 R4 R6 random" : "R2 R6 R7 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule